// File: doc/BRIEF.md
# Return-to-One Single-Wire Bit Engine

This block handles the bit-level timing on one bidirectional open-drain data wire that a peripheral shares with a host. Every bit is a frame. Either side starts it by pulling the wire low. The data level is then presented inside a window measured from that falling edge. The wire then goes back high and must stay high until the full bit time has passed, so the next frame cannot start too early.

In receive mode the engine synchronises the wire, finds the falling edge and rejects low pulses that are too short. It samples the level partway through the data window, waits for the recovery period, and then strobes out one decoded bit. A wire held low too long, or pulled low again during recovery, raises a one-cycle error and the bit is dropped. In transmit mode the engine accepts one bit through a request/done handshake. It pulls the wire low for a start pulse, keeps it low through the data window for a zero, and lets it float high for the rest of the frame. It only ever pulls low or releases the wire. All timing values are parameters counted in system clock cycles. Byte assembly belongs to the logic above this block.

Top module: `rto_bit_engine`

## Requirements
- R1: After reset, `pull_o`, `tx_done_o`, `rx_valid_o` and `rx_err_o` are all 0.
- R2: `pull_o` is 1 only while a transmit frame is in progress. Receiving a bit never makes the engine pull the wire.
- R3: A transmitted 1 pulls the wire low for exactly START_CYC consecutive cycles and then releases it.
- R4: A transmitted 0 pulls the wire low for exactly STOP_CYC consecutive cycles and then releases it.
- R5: `tx_done_o` is a one-cycle pulse in the last cycle of a CYCLE_CYC-cycle transmit frame. The first pulled cycle counts as cycle 1.
- R6: A received bit is 1 if the wire is high at the sample point, and 0 if it is low there. The sample point is (SETUP_CYC+HOLD_CYC)/2 cycles after the start edge.
- R7: A received bit is reported by exactly one `rx_valid_o` pulse, after the wire has stayed high until CYCLE_CYC cycles from the start edge. `rx_bit_o` holds the decoded value.
- R8: A low pulse shorter than START_CYC cycles is ignored: no `rx_valid_o` and no `rx_err_o`.
- R9: If the wire is still low STUCK_CYC cycles after the start edge, `rx_err_o` pulses once and no bit is reported. The engine returns to idle once the wire is high, and the next bit is decoded normally.
- R10: A falling edge during the recovery period, before CYCLE_CYC cycles have passed, gives one `rx_err_o` pulse and no `rx_valid_o`.
- R11: A transmit request that arrives while a bit is being received is held off until that bit has been reported. It then runs as a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Wire level as seen at the pad (asynchronous) |
| pull_o | output | 1 | 1 = pull wire low, 0 = release (open drain) |
| tx_req_i | input | 1 | Transmit request, held until `tx_done_o` |
| tx_bit_i | input | 1 | Bit to send, captured when the request is accepted |
| tx_done_o | output | 1 | One-cycle pulse at the end of the transmit frame |
| rx_valid_o | output | 1 | One-cycle strobe: a bit was received |
| rx_bit_o | output | 1 | Last received bit value |
| rx_err_o | output | 1 | One-cycle strobe: stuck-low or early-start fault |

## Verification
The assertions assume the timing parameters are strictly ordered: START_CYC < SETUP_CYC < HOLD_CYC <= STOP_CYC < CYCLE_CYC. They also assume `tx_req_i` stays high until `tx_done_o` is seen, so that the pull pattern and the done pulse of one frame line up with the frame counter. The bench drives the wire only with lows whose lengths keep clear of the sample point and the start threshold by several cycles, so the synchroniser delay cannot move a decision. It drops the request on the cycle where done is seen.

// File: rtl/rto_pkg.sv
package rto_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RX_START = 3'd1,
    ST_RX_DATA  = 3'd2,
    ST_RX_STOP  = 3'd3,
    ST_RX_RECOV = 3'd4,
    ST_RX_HALT  = 3'd5,
    ST_TX       = 3'd6
  } rto_state_e;

endpackage

// File: rtl/rto_line_sync.sv
module rto_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  // shift chain, idle level of the wire is high
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = line_i;
      end else begin : g_next
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign line_o = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/rto_cycle_timer.sv
module rto_cycle_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear_i | (en_i & (cnt_q != CNT_TOP));
    cnt_d  = clear_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rto_frame_ctrl.sv
module rto_frame_ctrl
  import rto_pkg::*;
#(
  parameter int START_CYC = 5,
  parameter int SETUP_CYC = 10,
  parameter int HOLD_CYC  = 20,
  parameter int STOP_CYC  = 30,
  parameter int CYCLE_CYC = 45,
  parameter int STUCK_CYC = 100,
  parameter int CNT_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tx_req_i,
  input  logic             tx_bit_i,
  output logic             tmr_clear_o,
  output logic             tmr_en_o,
  output logic             pull_o,
  output logic             tx_done_o,
  output logic             rx_valid_o,
  output logic             rx_bit_o,
  output logic             rx_err_o
);

  localparam int SAMPLE_CYC = (SETUP_CYC + HOLD_CYC) / 2;
  localparam logic [CNT_W-1:0] C_START_LAST = CNT_W'(START_CYC - 1);
  localparam logic [CNT_W-1:0] C_START      = CNT_W'(START_CYC);
  localparam logic [CNT_W-1:0] C_SAMPLE     = CNT_W'(SAMPLE_CYC);
  localparam logic [CNT_W-1:0] C_STOP       = CNT_W'(STOP_CYC);
  localparam logic [CNT_W-1:0] C_CYC_LAST   = CNT_W'(CYCLE_CYC - 1);
  localparam logic [CNT_W-1:0] C_STUCK      = CNT_W'(STUCK_CYC);

  rto_state_e state_q, state_d;
  logic       txb_q, txb_d, txb_en;
  logic       rxb_q, rxb_en;

  // next-state process
  always_comb begin
    state_d    = state_q;
    txb_d      = txb_q;
    txb_en     = 1'b0;
    rxb_en     = 1'b0;
    tx_done_o  = 1'b0;
    rx_valid_o = 1'b0;
    rx_err_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall_i) begin
          state_d = ST_RX_START;
        end else if (tx_req_i) begin
          state_d = ST_TX;
          txb_d   = tx_bit_i;
          txb_en  = 1'b1;
        end
      end
      ST_RX_START: begin
        if (line_i) begin
          state_d = ST_IDLE;              // too short: glitch
        end else if (cnt_i == C_START_LAST) begin
          state_d = ST_RX_DATA;
        end
      end
      ST_RX_DATA: begin
        if (cnt_i == C_SAMPLE) begin
          rxb_en  = 1'b1;
          state_d = ST_RX_STOP;
        end
      end
      ST_RX_STOP: begin
        if (line_i) begin
          state_d = ST_RX_RECOV;
        end else if (cnt_i >= C_STUCK) begin
          rx_err_o = 1'b1;
          state_d  = ST_RX_HALT;
        end
      end
      ST_RX_RECOV: begin
        if (!line_i) begin
          rx_err_o = 1'b1;
          state_d  = ST_RX_HALT;
        end else if (cnt_i >= C_CYC_LAST) begin
          rx_valid_o = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      ST_RX_HALT: begin
        if (line_i) begin
          state_d = ST_IDLE;
        end
      end
      ST_TX: begin
        if (cnt_i == C_CYC_LAST) begin
          tx_done_o = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      txb_q   <= 1'b1;
      rxb_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      if (txb_en) begin
        txb_q <= txb_d;
      end
      if (rxb_en) begin
        rxb_q <= line_i;
      end
    end
  end

  assign tmr_clear_o = (state_q == ST_IDLE);
  assign tmr_en_o    = (state_q != ST_IDLE);
  assign pull_o      = (state_q == ST_TX) &&
                       ((cnt_i < C_START) || (!txb_q && (cnt_i < C_STOP)));
  assign rx_bit_o    = rxb_q;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && rx_err_o)); // R9
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o); // R5
  AST_PULL_FRAME_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_o) |-> (cnt_i == '0)); // R3
  AST_PULL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_o) |-> ((cnt_i == C_START) || (cnt_i == C_STOP))); // R4

endmodule

// File: rtl/rto_bit_engine.sv
module rto_bit_engine #(
  parameter int START_CYC = 5,
  parameter int SETUP_CYC = 10,
  parameter int HOLD_CYC  = 20,
  parameter int STOP_CYC  = 30,
  parameter int CYCLE_CYC = 45,
  parameter int STUCK_CYC = 100,
  parameter int SYNC_STG  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic pull_o,
  input  logic tx_req_i,
  input  logic tx_bit_i,
  output logic tx_done_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  output logic rx_err_o
);

  localparam int CNT_MAX = (STUCK_CYC > CYCLE_CYC) ? STUCK_CYC : CYCLE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 2);

  logic             line_s;
  logic             fall_s;
  logic             tmr_clear;
  logic             tmr_en;
  logic [CNT_W-1:0] cnt;

  rto_line_sync #(
    .STAGES (SYNC_STG)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .line_o (line_s),
    .fall_o (fall_s)
  );

  rto_cycle_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (tmr_clear),
    .en_i    (tmr_en),
    .cnt_o   (cnt)
  );

  rto_frame_ctrl #(
    .START_CYC (START_CYC),
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .STOP_CYC  (STOP_CYC),
    .CYCLE_CYC (CYCLE_CYC),
    .STUCK_CYC (STUCK_CYC),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_i      (line_s),
    .fall_i      (fall_s),
    .cnt_i       (cnt),
    .tx_req_i    (tx_req_i),
    .tx_bit_i    (tx_bit_i),
    .tmr_clear_o (tmr_clear),
    .tmr_en_o    (tmr_en),
    .pull_o      (pull_o),
    .tx_done_o   (tx_done_o),
    .rx_valid_o  (rx_valid_o),
    .rx_bit_o    (rx_bit_o),
    .rx_err_o    (rx_err_o)
  );

  AST_VALID_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> line_s); // R7
  AST_VALID_AFTER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (cnt >= CNT_W'(CYCLE_CYC - 1))); // R7
  AST_NO_PULL_ON_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o || rx_err_o) |-> !pull_o); // R2

endmodule

// File: tb/tb_rto_bit_engine.sv
module tb_rto_bit_engine;

  localparam int START_CYC = 5;
  localparam int STOP_CYC  = 30;
  localparam int CYCLE_CYC = 45;

  logic clk;
  logic rst_n;
  logic ext_low;
  logic line;
  logic pull_o, tx_req, tx_bit, tx_done_o, rx_valid_o, rx_bit_o, rx_err_o;

  int n_chk;
  int n_fail;
  int n_valid, n_err, n_pull, n_done;
  logic last_bit;
  int cyc;

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  assign line = ~(ext_low | pull_o);

  rto_bit_engine dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .line_i     (line),
    .pull_o     (pull_o),
    .tx_req_i   (tx_req),
    .tx_bit_i   (tx_bit),
    .tx_done_o  (tx_done_o),
    .rx_valid_o (rx_valid_o),
    .rx_bit_o   (rx_bit_o),
    .rx_err_o   (rx_err_o)
  );

  always @(negedge clk) begin
    if (rx_valid_o) begin
      n_valid++;
      last_bit = rx_bit_o;
    end
    if (rx_err_o) n_err++;
    if (pull_o) n_pull++;
    if (tx_done_o) n_done++;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(posedge clk);
    n_valid = 0; n_err = 0; n_pull = 0; n_done = 0;
  endtask

  task automatic drive_low(input int low_len, input int total);
    @(negedge clk);
    ext_low = 1'b1;
    repeat (low_len) @(negedge clk);
    ext_low = 1'b0;
    repeat (total - low_len) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(pull_o == 0, "R1 pull", pull_o, 0);
    check({tx_done_o, rx_valid_o, rx_err_o} == 3'b000, "R1 strobes",
          {tx_done_o, rx_valid_o, rx_err_o}, 0);
  endtask

  task automatic t_rx_bit(input bit b);
    clr_mon();
    drive_low(b ? 8 : 25, 70);
    @(posedge clk);
    check(n_valid == 1, "R7 one valid", n_valid, 1);
    check(last_bit == b, "R6 decoded bit", last_bit, b);
    check(n_err == 0, "R7 no err", n_err, 0);
    check(n_pull == 0, "R2 no pull on rx", n_pull, 0);
  endtask

  task automatic t_glitch();
    clr_mon();
    drive_low(2, 60);
    @(posedge clk);
    check(n_valid == 0, "R8 glitch valid", n_valid, 0);
    check(n_err == 0, "R8 glitch err", n_err, 0);
  endtask

  task automatic t_stuck();
    clr_mon();
    drive_low(150, 170);
    @(posedge clk);
    check(n_err == 1, "R9 stuck err", n_err, 1);
    check(n_valid == 0, "R9 stuck valid", n_valid, 0);
    t_rx_bit(1'b0);   // R9 recovery: next bit decodes
  endtask

  task automatic t_early();
    clr_mon();
    drive_low(8, 30);
    drive_low(8, 60);
    @(posedge clk);
    check(n_err == 1, "R10 early err", n_err, 1);
    check(n_valid == 0, "R10 early valid", n_valid, 0);
  endtask

  task automatic t_tx(input bit b);
    int lows;
    int len;
    bit started;
    lows = 0; len = 0; started = 0;
    clr_mon();
    @(negedge clk);
    tx_req = 1'b1;
    tx_bit = b;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pull_o) started = 1;
      if (started) len++;
      if (pull_o) lows++;
      if (tx_done_o) begin
        tx_req = 1'b0;
        break;
      end
    end
    if (b) check(lows == START_CYC, "R3 low length", lows, START_CYC);
    else   check(lows == STOP_CYC, "R4 low length", lows, STOP_CYC);
    check(len == CYCLE_CYC, "R5 frame length", len, CYCLE_CYC);
    repeat (5) @(negedge clk);
    check(n_done == 1, "R5 one done", n_done, 1);
    check(pull_o == 0, "R2 released after tx", pull_o, 0);
    check(n_valid == 0 && n_err == 0, "R2 own frame not received", n_valid + n_err, 0);
  endtask

  task automatic t_tx_during_rx();
    int early_pull;
    int lows;
    early_pull = 0; lows = 0;
    clr_mon();
    @(negedge clk);
    ext_low = 1'b1;
    repeat (3) @(negedge clk);
    tx_req = 1'b1;
    tx_bit = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (i == 21) ext_low = 1'b0;
      if (pull_o && n_valid == 0) early_pull++;
      if (pull_o) lows++;
      if (tx_done_o) begin
        tx_req = 1'b0;
        break;
      end
    end
    repeat (5) @(negedge clk);
    check(early_pull == 0, "R11 no pull before rx done", early_pull, 0);
    check(n_valid == 1 && last_bit == 1'b0, "R11 rx bit kept", n_valid, 1);
    check(n_done == 1, "R11 tx completes", n_done, 1);
    check(lows == START_CYC, "R11 tx low length", lows, START_CYC);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    ext_low = 1'b0; tx_req = 1'b0; tx_bit = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_rx_bit(1'b1);
    t_rx_bit(1'b0);
    t_rx_bit(1'b1);
    t_glitch();
    t_stuck();
    t_early();
    t_tx(1'b1);
    t_tx(1'b0);
    t_tx_during_rx();
    t_rx_bit(1'b0);
    summary();
    $finish;
  end

endmodule